// File: doc/BRIEF.md
# Sleep-Aware Interrupt Vectoring Controller

This block sits beside a processor core and decides, at each instruction boundary, whether an interrupt is taken and how. It holds one sticky pending bit per interrupt source, filters the pending set against the core's sleep state, and picks the qualifying source with the lowest vector address. It then issues a one-cycle bundle of control strobes to the core: push the current PC onto the stack, clear the global interrupt enable, and load the PC with the vector target. Source 0 is the reset vector. When it is selected, the block requests a core reset instead. The stack memory and the instruction execution stay in the core.

The decision runs only when `boundary_i` is high. The result is registered and appears for exactly one cycle after that edge. The controller is a three-state machine. `ST_IDLE` issues nothing. `ST_VEC` drives the vectoring bundle. `ST_RST` drives the reset bundle. The next state depends only on the decision made at the current edge:
- take-reset leads to `ST_RST`;
- take-vector leads to `ST_VEC`;
- no-take leads to `ST_IDLE`.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A pulse on `raise_i[k]` sets pending bit k, and the bit stays set until it is serviced or cleared. A pulse on `clear_i[k]` alone removes the bit. A raise and a clear on the same cycle leave the bit set.
- R2: Source k has vector address 2*k. Among the qualifying pending sources, the one with the lowest index is selected.
- R3: When `asleep_i` is low, every pending source qualifies.
- R4: When `asleep_i` is high, source k qualifies only if `wake_mask_i[k*SLP_W +: SLP_W] & sleep_mode_i` is nonzero. A pending source that fails this test is skipped in favour of the next one that passes.
- R5: If source 0 is selected, the cycle after the boundary shows `core_rst_o`=1, `pc_load_o`=1 and `pc_new_o`=0, with no push and no enable clear. This happens whatever the value of `gie_i`. The reset clears every pending bit, including any raised in the same cycle. The core also clears its remaining instruction-cycle count on `core_rst_o`.
- R6: If `gie_i`=1 and a source k>0 is selected, the cycle after the boundary shows:
  - `push_o`=1, with `push_pc_o` equal to `pc_i` captured at the boundary;
  - `push_bytes_o`=2 when PC_W≤16 and 3 otherwise;
  - `clr_gie_o`=1;
  - `pc_load_o`=1 with the target of R9.

  Pending bit k is cleared.
- R7: If `gie_i`=0 and a source k>0 is selected, no strobe is issued and the pending bits are unchanged.
- R8: A boundary with `last_reti_i`=1 takes no decision, so the next boundary is the earliest at which a request is serviced.
- R9: The load target is (2*k + `tbl_off_i`) mod PROG_WORDS.
- R10: Strobes appear only in the single cycle after a clock edge at which `boundary_i` was high. Without a boundary, all outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | NUM_SRC | Per-source request pulses |
| clear_i | input | NUM_SRC | Per-source cancel pulses |
| gie_i | input | 1 | Global interrupt enable flag |
| asleep_i | input | 1 | Core is in a sleep state |
| sleep_mode_i | input | SLP_W | One-hot current sleep mode |
| wake_mask_i | input | NUM_SRC*SLP_W | Per-source sleep modes it can wake from |
| tbl_off_i | input | PC_W | Vector table base offset in words |
| pc_i | input | PC_W | Current program counter |
| last_reti_i | input | 1 | Last retired instruction was a return-from-interrupt |
| boundary_i | input | 1 | Instruction boundary, decision point |
| push_o | output | 1 | Push PC request |
| push_bytes_o | output | 2 | Bytes to push |
| push_pc_o | output | PC_W | PC value to push |
| clr_gie_o | output | 1 | Clear global enable request |
| pc_load_o | output | 1 | PC load strobe |
| pc_new_o | output | PC_W | PC load value |
| core_rst_o | output | 1 | Core reset request |

## Verification
Every result is due exactly one cycle after the edge that sampled `boundary_i` high, and it lasts for one cycle only. The bench drives a boundary for one cycle from the falling edge and checks all outputs at the next falling edge. It then checks that the following cycle is quiet. The effects on pending state are not visible at once. They are observed through a later boundary, where the same source is either taken or left alone, and that is how clears, flushes and held-off requests are confirmed.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VEC  = 2'd1,
        ST_RST  = 2'd2
    } irqv_state_e;

    function automatic logic [1:0] push_byte_count(input int pc_bits);
        return (pc_bits > 16) ? 2'd3 : 2'd2;
    endfunction

endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] raise_i,
    input  logic [NUM_SRC-1:0] clear_i,
    input  logic [NUM_SRC-1:0] svc_i,
    input  logic               flush_i,
    output logic [NUM_SRC-1:0] pend_o
);

    logic [NUM_SRC-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (flush_i) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~(clear_i | svc_i)) | raise_i;
        end
    end

    assign pend_o = pend_q;

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_chk
            // R1: a raise without flush leaves the bit set
            a_r1_raise_sticks: assert property (@(posedge clk) disable iff (!rst_n)
                (raise_i[k] && !flush_i) |=> pend_q[k]);
            // R1: bit without raise, clear or service holds its value
            a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_q[k] && !raise_i[k] && !clear_i[k] && !svc_i[k] && !flush_i) |=> pend_q[k]);
        end
    endgenerate

    // R5: a reset decision empties the pending set
    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (pend_q == '0));

endmodule

// File: rtl/irqv_select.sv
module irqv_select #(
    parameter int NUM_SRC = 16,
    parameter int SLP_W   = 4,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       pend_i,
    input  logic                     asleep_i,
    input  logic [SLP_W-1:0]         sleep_mode_i,
    input  logic [NUM_SRC*SLP_W-1:0] wake_mask_i,
    output logic                     sel_valid_o,
    output logic [IDX_W-1:0]         sel_idx_o
);

    logic [NUM_SRC-1:0] qual;

    generate
        for (genvar k = 0; k < NUM_SRC; k++) begin : g_qual
            assign qual[k] = pend_i[k] &
                (!asleep_i || (|(wake_mask_i[k*SLP_W +: SLP_W] & sleep_mode_i)));
        end
    endgenerate

    always_comb begin
        sel_valid_o = 1'b0;
        sel_idx_o   = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (qual[k]) begin
                sel_valid_o = 1'b1;
                sel_idx_o   = IDX_W'(k);
            end
        end
    end

    // R4: an asleep selection must share a bit with the sleep mode
    a_r4_wake_match: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid_o && asleep_i) |->
            (|(wake_mask_i[sel_idx_o*SLP_W +: SLP_W] & sleep_mode_i)));
    // R2: the selected source is pending
    a_r2_sel_pending: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid_o |-> pend_i[sel_idx_o]);

endmodule

// File: rtl/irqv_target.sv
module irqv_target #(
    parameter int NUM_SRC    = 16,
    parameter int PC_W       = 16,
    parameter int PROG_WORDS = 4096,
    parameter int VEC_STRIDE = 2,
    localparam int IDX_W     = $clog2(NUM_SRC)
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [PC_W-1:0]  tbl_off_i,
    output logic [PC_W-1:0]  target_o
);

    logic [31:0] raw_sum;

    always_comb begin
        raw_sum  = 32'(tbl_off_i) + 32'(idx_i) * 32'(VEC_STRIDE);
        target_o = PC_W'(raw_sum % 32'(PROG_WORDS));
    end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NUM_SRC    = 16,
    parameter int SLP_W      = 4,
    parameter int PC_W       = 16,
    parameter int PROG_WORDS = 4096,
    localparam int IDX_W     = $clog2(NUM_SRC)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       raise_i,
    input  logic [NUM_SRC-1:0]       clear_i,
    input  logic                     gie_i,
    input  logic                     asleep_i,
    input  logic [SLP_W-1:0]         sleep_mode_i,
    input  logic [NUM_SRC*SLP_W-1:0] wake_mask_i,
    input  logic [PC_W-1:0]          tbl_off_i,
    input  logic [PC_W-1:0]          pc_i,
    input  logic                     last_reti_i,
    input  logic                     boundary_i,
    output logic                     push_o,
    output logic [1:0]               push_bytes_o,
    output logic [PC_W-1:0]          push_pc_o,
    output logic                     clr_gie_o,
    output logic                     pc_load_o,
    output logic [PC_W-1:0]          pc_new_o,
    output logic                     core_rst_o
);

    localparam logic [1:0] PUSH_BYTES = push_byte_count(PC_W);

    irqv_state_e        state_q, state_d;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] svc;
    logic               sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    logic [PC_W-1:0]    target;
    logic [PC_W-1:0]    tgt_q;
    logic [PC_W-1:0]    save_pc_q;
    logic               take, go_rst, go_vec;

    irqv_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .raise_i (raise_i),
        .clear_i (clear_i),
        .svc_i   (svc),
        .flush_i (go_rst),
        .pend_o  (pend)
    );

    irqv_select #(.NUM_SRC(NUM_SRC), .SLP_W(SLP_W)) u_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .pend_i       (pend),
        .asleep_i     (asleep_i),
        .sleep_mode_i (sleep_mode_i),
        .wake_mask_i  (wake_mask_i),
        .sel_valid_o  (sel_valid),
        .sel_idx_o    (sel_idx)
    );

    irqv_target #(.NUM_SRC(NUM_SRC), .PC_W(PC_W), .PROG_WORDS(PROG_WORDS),
                  .VEC_STRIDE(2)) u_tgt (
        .idx_i     (sel_idx),
        .tbl_off_i (tbl_off_i),
        .target_o  (target)
    );

    assign take   = boundary_i && !last_reti_i && sel_valid;
    assign go_rst = take && (sel_idx == '0);
    assign go_vec = take && (sel_idx != '0) && gie_i;

    always_comb begin
        svc = '0;
        if (go_vec) svc[sel_idx] = 1'b1;
    end

    always_comb begin
        if (go_rst)      state_d = ST_RST;
        else if (go_vec) state_d = ST_VEC;
        else             state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            tgt_q     <= '0;
            save_pc_q <= '0;
        end else begin
            state_q <= state_d;
            if (go_vec) begin
                tgt_q     <= target;
                save_pc_q <= pc_i;
            end
        end
    end

    always_comb begin
        push_o       = 1'b0;
        push_bytes_o = 2'd0;
        push_pc_o    = '0;
        clr_gie_o    = 1'b0;
        pc_load_o    = 1'b0;
        pc_new_o     = '0;
        core_rst_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_VEC: begin
                push_o       = 1'b1;
                push_bytes_o = PUSH_BYTES;
                push_pc_o    = save_pc_q;
                clr_gie_o    = 1'b1;
                pc_load_o    = 1'b1;
                pc_new_o     = tgt_q;
            end
            ST_RST: begin
                core_rst_o = 1'b1;
                pc_load_o  = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: reset strobe loads zero and never pushes
    a_r5_reset_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |-> (!push_o && !clr_gie_o && pc_load_o && pc_new_o == '0));
    // R6: a push follows a boundary that saw the enable set
    a_r6_push_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> ($past(gie_i) && $past(boundary_i)));
    // R8: a boundary right after a return takes nothing
    a_r8_reti_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_i && last_reti_i) |=> (!push_o && !core_rst_o && !pc_load_o));
    // R9: load target inside program space
    a_r9_target_range: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (32'(pc_new_o) < 32'(PROG_WORDS)));
    // R10: no boundary, no strobe in the next cycle
    a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> (!pc_load_o && !push_o && !core_rst_o));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;

    localparam int NS = 16;
    localparam int SW = 4;
    localparam int PW = 16;
    localparam int PWORDS = 4096;

    logic            clk = 0;
    logic            rst_n = 0;
    logic [NS-1:0]   raise_i = '0, clear_i = '0;
    logic            gie_i = 0, asleep_i = 0, last_reti_i = 0, boundary_i = 0;
    logic [SW-1:0]   sleep_mode_i = '0;
    logic [NS*SW-1:0] wake_mask_i = '0;
    logic [PW-1:0]   tbl_off_i = '0, pc_i = '0;
    logic            push_o, clr_gie_o, pc_load_o, core_rst_o;
    logic [1:0]      push_bytes_o;
    logic [PW-1:0]   push_pc_o, pc_new_o;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irq_vector_ctrl #(.NUM_SRC(NS), .SLP_W(SW), .PC_W(PW), .PROG_WORDS(PWORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .clear_i(clear_i),
        .gie_i(gie_i), .asleep_i(asleep_i), .sleep_mode_i(sleep_mode_i),
        .wake_mask_i(wake_mask_i), .tbl_off_i(tbl_off_i), .pc_i(pc_i),
        .last_reti_i(last_reti_i), .boundary_i(boundary_i),
        .push_o(push_o), .push_bytes_o(push_bytes_o), .push_pc_o(push_pc_o),
        .clr_gie_o(clr_gie_o), .pc_load_o(pc_load_o), .pc_new_o(pc_new_o),
        .core_rst_o(core_rst_o)
    );

    function automatic logic [PW-1:0] exp_tgt(input int idx, input int off);
        return PW'((2 * idx + off) % PWORDS);
    endfunction

    // expected packed: {push, bytes, push_pc, clr_gie, load, pc_new, rst}
    task automatic expect_out(input string req, input logic ep, input logic [PW-1:0] epc,
                              input logic eload, input logic [PW-1:0] enew, input logic erst);
        logic [2*PW+5:0] act, exp;
        act = {push_o, push_bytes_o, push_pc_o, clr_gie_o, pc_load_o, pc_new_o, core_rst_o};
        exp = {ep, ep ? 2'd2 : 2'd0, ep ? epc : '0, ep, eload, eload ? enew : '0, erst};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic expect_quiet(input string req);
        expect_out(req, 1'b0, '0, 1'b0, '0, 1'b0);
    endtask

    task automatic pulse_raise(input logic [NS-1:0] r, input logic [NS-1:0] c);
        raise_i = r; clear_i = c;
        @(negedge clk);
        raise_i = '0; clear_i = '0;
    endtask

    // one boundary; returns at the negedge where results are due
    task automatic do_boundary(input logic g, input logic reti);
        gie_i = g; last_reti_i = reti; boundary_i = 1;
        @(negedge clk);
        boundary_i = 0; last_reti_i = 0;
    endtask

    task automatic t_basic;
        tbl_off_i = 16'h0100; pc_i = 16'h1234;
        pulse_raise(16'h0008, '0);
        do_boundary(1, 0);
        expect_out("R6 basic vector", 1, 16'h1234, 1, exp_tgt(3, 'h100), 0);
        @(negedge clk);
        expect_quiet("R10 strobe one cycle");
        do_boundary(1, 0);
        expect_quiet("R6 serviced bit cleared");
    endtask

    task automatic t_priority;
        tbl_off_i = 16'h0040; pc_i = 16'h0222;
        pulse_raise(16'h0024, '0);
        do_boundary(1, 0);
        expect_out("R2 lowest index wins", 1, 16'h0222, 1, exp_tgt(2, 'h40), 0);
        do_boundary(1, 0);
        expect_out("R2 next source later", 1, 16'h0222, 1, exp_tgt(5, 'h40), 0);
    endtask

    task automatic t_sleep;
        tbl_off_i = '0; pc_i = 16'h0300;
        wake_mask_i = '0;
        wake_mask_i[2*SW +: SW] = 4'b0001;
        wake_mask_i[6*SW +: SW] = 4'b0010;
        asleep_i = 1; sleep_mode_i = 4'b0010;
        pulse_raise(16'h0044, '0);
        do_boundary(1, 0);
        expect_out("R4 skip non-waking source", 1, 16'h0300, 1, exp_tgt(6, 0), 0);
        sleep_mode_i = 4'b0100;
        do_boundary(1, 0);
        expect_quiet("R4 no source can wake");
        asleep_i = 0;
        do_boundary(1, 0);
        expect_out("R3 awake all qualify", 1, 16'h0300, 1, exp_tgt(2, 0), 0);
    endtask

    task automatic t_gie_off;
        tbl_off_i = '0; pc_i = 16'h0400;
        pulse_raise(16'h0010, '0);
        do_boundary(0, 0);
        expect_quiet("R7 disabled no action");
        do_boundary(1, 0);
        expect_out("R7 pending kept", 1, 16'h0400, 1, exp_tgt(4, 0), 0);
    endtask

    task automatic t_reset;
        pulse_raise(16'h0081, '0);
        do_boundary(0, 0);
        expect_out("R5 reset bypasses enable", 0, '0, 1, '0, 1);
        do_boundary(1, 0);
        expect_quiet("R5 reset flushed pending");
    endtask

    task automatic t_reti;
        pc_i = 16'h0500; tbl_off_i = '0;
        pulse_raise(16'h0200, '0);
        do_boundary(1, 1);
        expect_quiet("R8 held after return");
        do_boundary(1, 0);
        expect_out("R8 taken next boundary", 1, 16'h0500, 1, exp_tgt(9, 0), 0);
    endtask

    task automatic t_no_boundary;
        pc_i = 16'h0600;
        pulse_raise(16'h0002, '0);
        gie_i = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            expect_quiet("R10 no boundary no strobe");
        end
        do_boundary(1, 0);
        expect_out("R10 boundary fires", 1, 16'h0600, 1, exp_tgt(1, 0), 0);
    endtask

    task automatic t_raise_clear;
        pc_i = 16'h0700;
        pulse_raise(16'h0800, 16'h0800);
        do_boundary(1, 0);
        expect_out("R1 raise beats clear", 1, 16'h0700, 1, exp_tgt(11, 0), 0);
        pulse_raise(16'h0400, '0);
        pulse_raise('0, 16'h0400);
        do_boundary(1, 0);
        expect_quiet("R1 clear removes bit");
    endtask

    task automatic t_wrap;
        pc_i = 16'h0800; tbl_off_i = 16'd4095;
        pulse_raise(16'h0002, '0);
        do_boundary(1, 0);
        expect_out("R9 target wraps", 1, 16'h0800, 1, 16'd1, 0);
        tbl_off_i = 16'd4000;
        pulse_raise(16'h8000, '0);
        do_boundary(1, 0);
        expect_out("R9 target no wrap", 1, 16'h0800, 1, 16'd4030, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        expect_quiet("R10 reset state");
        rst_n = 1;
        @(negedge clk);
        expect_quiet("R10 idle after reset");
        t_basic();
        t_priority();
        t_sleep();
        t_gie_off();
        t_reset();
        t_reti();
        t_no_boundary();
        t_raise_clear();
        t_wrap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule